// File: doc/BRIEF.md
# Serial Interrupt Host Deserializer

This block is the host end of a serial interrupt line shared by several bus peripherals. The host pulls the open-drain line low to mark the start of a frame. It then counts a fixed sequence of three-clock slots. During the first clock of each slot it reads the line to find out whether the peripheral that owns that slot is pulling it low. The block closes each frame by driving a stop pulse. Once a frame has completed, the per-slot results appear on 17 level outputs. Slot 16 carries the I/O-check indication.

A single control word sets three things: the master enable, the run mode and the width of the start pulse. The run mode is either continuous (a new frame every time) or quiet (the line stays released until a peripheral asks for a frame). The line is modelled as two signals: the level seen on the wire and a pull-low request driven by this block. The wired-AND of every driver on the line is left to the board or the surrounding logic.

Top module: `serirq_host`

## Requirements
- R1: While control bit 31 (enable) is 0, `serirq_pull` is 0 and `irq_level` is all zeros. Both hold from the first clock after the write that clears the bit. Activity on the line has no effect during this time. Re-enabling the block does not bring back values from an earlier frame.
- R2: After bit 31 is set from the disabled state, the host starts a start frame on the next clock, whatever mode is selected.
- R3: Control bits 25:24 set the number of clocks the host drives low for a start frame: 00 gives 4, 01 gives 6, 10 gives 8 and 11 gives 8.
- R4: Right after the start pulse come 17 slots, numbered 0 to 16, of 3 clocks each. The host releases the line for all 51 of those clocks. If the line is low in the first clock of slot s, bit s of `irq_level` is 1 for that frame, otherwise 0. Bit 16 is the I/O-check slot.
- R5: A low level on the line in the second or third clock of a slot does not change that slot's result.
- R6: After slot 16, the host drives a stop pulse and then releases the line for one clock. The stop pulse is 3 clocks long if the frame began in continuous mode (bit 30 = 0) and 2 clocks long if it began in quiet mode (bit 30 = 1).
- R7: In continuous mode, the next start frame begins on the clock right after the released clock that follows the stop pulse.
- R8: In quiet mode, the host keeps the line released after the stop frame until it sees the line low for one clock. It then drives low for the start width minus one clock, and slot 0 follows.
- R9: `irq_level` changes only on the clock edge that ends the last slot of a frame. It holds its value during the stop pulse, the idle time and all of the next frame.
- R10: A control write takes effect at the next start frame. The frame in progress keeps its stop width, and a host that is idling in quiet mode keeps waiting for a peripheral request.
- R11: After reset, the block is disabled: the line is released and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Bus clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| serirq_in | input | 1 | Level currently present on the shared interrupt line |
| serirq_pull | output | 1 | 1 requests the line be pulled low; 0 releases it |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: bit 31 enable, bit 30 quiet mode, bits 25:24 start width |
| irq_level | output | 17 | Per-slot interrupt levels from the last complete frame; bit 16 is I/O check |

## Verification
The bench changes the control word in the middle of a frame. A design that applied the new settings at once would shorten the stop pulse or change the start width of the frame already under way. The bench also pulls the line low in the recovery and turnaround clocks of unused slots, which catches a sampler that is off by one clock in its phase count. During quiet idle it restarts the frame with a single-clock request, so a host that counts the full width after the request would show a start pulse one clock too long. The bench also disables the block partway through a start frame and re-enables it later. This exposes outputs that were not cleared, or stale results that come back before a new frame has completed.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

    localparam int CTL_EN_BIT    = 31;
    localparam int CTL_QUIET_BIT = 30;
    localparam int CTL_WID_HI    = 25;
    localparam int CTL_WID_LO    = 24;
    localparam int CNT_W         = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SLOT,
        ST_STOP,
        ST_TAR,
        ST_QWAIT
    } sq_state_e;

    typedef struct packed {
        logic       en;
        logic       quiet;
        logic [1:0] wsel;
    } sq_cfg_t;

    // Start pulse width in clocks for a width-select code.
    function automatic logic [CNT_W-1:0] start_clocks(input logic [1:0] wsel);
        case (wsel)
            2'b00:   return CNT_W'(4);
            2'b01:   return CNT_W'(6);
            default: return CNT_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/serirq_ctl_reg.sv
module serirq_ctl_reg
    import serirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output sq_cfg_t     cfg
);
    sq_cfg_t cfg_d, cfg_q;

    // Bits with no function are simply not stored.
    logic wdata_unused;
    assign wdata_unused = ^{wdata[29:26], wdata[23:0]};

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.en    = wdata[CTL_EN_BIT];
            cfg_d.quiet = wdata[CTL_QUIET_BIT];
            cfg_d.wsel  = wdata[CTL_WID_HI:CTL_WID_LO];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/serirq_frame_fsm.sv
module serirq_frame_fsm
    import serirq_pkg::*;
#(
    parameter  int NUM_SLOTS = 17,
    parameter  int SLOT_CLKS = 3,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int PH_W      = $clog2(SLOT_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sq_cfg_t           cfg,
    input  logic              line_in,
    output logic              drive_low,
    output logic              smp_en,
    output logic [SLOT_W-1:0] smp_idx,
    output logic              commit
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(SLOT_CLKS - 1);

    typedef struct packed {
        sq_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
        logic [PH_W-1:0]   phase;
        logic              act_quiet;
    } fsm_regs_t;

    fsm_regs_t d, q;
    logic [CNT_W-1:0] width_now;

    assign width_now = start_clocks(cfg.wsel);

    always_comb begin
        d      = q;
        smp_en = 1'b0;
        commit = 1'b0;
        if (!cfg.en) begin
            d.state = ST_IDLE;
            d.cnt   = '0;
            d.slot  = '0;
            d.phase = '0;
        end else begin
            case (q.state)
                ST_IDLE: begin
                    d.state     = ST_START;
                    d.cnt       = width_now - CNT_W'(1);
                    d.act_quiet = cfg.quiet;
                end
                ST_START: begin
                    if (q.cnt == '0) begin
                        d.state = ST_SLOT;
                        d.slot  = '0;
                        d.phase = '0;
                    end else begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end
                end
                ST_SLOT: begin
                    smp_en = (q.phase == '0);
                    if (q.phase == LAST_PH) begin
                        d.phase = '0;
                        if (q.slot == LAST_SLOT) begin
                            commit  = 1'b1;
                            d.state = ST_STOP;
                            d.cnt   = q.act_quiet ? CNT_W'(1) : CNT_W'(2);
                        end else begin
                            d.slot = q.slot + SLOT_W'(1);
                        end
                    end else begin
                        d.phase = q.phase + PH_W'(1);
                    end
                end
                ST_STOP: begin
                    if (q.cnt == '0) d.state = ST_TAR;
                    else             d.cnt   = q.cnt - CNT_W'(1);
                end
                ST_TAR: begin
                    if (q.act_quiet) begin
                        d.state = ST_QWAIT;
                    end else begin
                        d.state     = ST_START;
                        d.cnt       = width_now - CNT_W'(1);
                        d.act_quiet = cfg.quiet;
                    end
                end
                ST_QWAIT: begin
                    if (!line_in) begin
                        // The request clock already counts toward the width.
                        d.state     = ST_START;
                        d.cnt       = width_now - CNT_W'(2);
                        d.act_quiet = cfg.quiet;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_IDLE;
            q.cnt       <= '0;
            q.slot      <= '0;
            q.phase     <= '0;
            q.act_quiet <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign drive_low = cfg.en && (q.state == ST_START || q.state == ST_STOP);
    assign smp_idx   = q.slot;

    assert_stop_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_STOP && $past(q.state) == ST_STOP && $past(q.state, 2) == ST_STOP)
        |=> q.state != ST_STOP)
        else $error("stop pulse longer than three clocks");

    assert_quiet_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_QWAIT && line_in && cfg.en) |=> q.state == ST_QWAIT)
        else $error("quiet idle left without a request");

    assert_slot_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.slot <= LAST_SLOT)
        else $error("slot index out of range");
endmodule

// File: rtl/serirq_slot_capture.sv
module serirq_slot_capture #(
    parameter  int NUM_SLOTS = 17,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 line_in,
    input  logic                 smp_en,
    input  logic [SLOT_W-1:0]    smp_idx,
    input  logic                 commit,
    output logic [NUM_SLOTS-1:0] irq_level
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] cap;
        logic [NUM_SLOTS-1:0] irq;
    } cap_regs_t;

    cap_regs_t d, q;

    always_comb begin
        d = q;
        if (!en) begin
            d = '0;
        end else begin
            if (smp_en) d.cap[smp_idx] = ~line_in;
            if (commit) d.irq = q.cap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_level = en ? q.irq : '0;

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !commit) |=> q.irq == $past(q.irq))
        else $error("irq levels moved outside a frame boundary");
endmodule

// File: rtl/serirq_host.sv
module serirq_host
    import serirq_pkg::*;
#(
    parameter  int NUM_SLOTS = 17,
    parameter  int SLOT_CLKS = 3,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 lclk,
    input  logic                 rst_n,
    input  logic                 serirq_in,
    output logic                 serirq_pull,
    input  logic                 ctl_we,
    input  logic [31:0]          ctl_wdata,
    output logic [NUM_SLOTS-1:0] irq_level
);
    sq_cfg_t           cfg;
    logic              smp_en;
    logic              commit;
    logic [SLOT_W-1:0] smp_idx;

    serirq_ctl_reg u_ctl (
        .clk   (lclk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .cfg   (cfg)
    );

    serirq_frame_fsm #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_CLKS (SLOT_CLKS)
    ) u_fsm (
        .clk       (lclk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .line_in   (serirq_in),
        .drive_low (serirq_pull),
        .smp_en    (smp_en),
        .smp_idx   (smp_idx),
        .commit    (commit)
    );

    serirq_slot_capture #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_cap (
        .clk       (lclk),
        .rst_n     (rst_n),
        .en        (cfg.en),
        .line_in   (serirq_in),
        .smp_en    (smp_en),
        .smp_idx   (smp_idx),
        .commit    (commit),
        .irq_level (irq_level)
    );

    assert_disable_R1: assert property (@(posedge lclk) disable iff (!rst_n)
        (ctl_we && !ctl_wdata[CTL_EN_BIT]) |=> (!serirq_pull && irq_level == '0))
        else $error("line or irq outputs active after disable");
endmodule

// File: tb/tb_serirq_host.sv
module tb_serirq_host;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          periph_pull = 1'b0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic          drv;
    logic          line_in;
    logic [NS-1:0] irq;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    assign line_in = !(drv || periph_pull);

    always #(CLK_PERIOD / 2) clk = ~clk;

    serirq_host dut (
        .lclk        (clk),
        .rst_n       (rst_n),
        .serirq_in   (line_in),
        .serirq_pull (drv),
        .ctl_we      (we),
        .ctl_wdata   (wdata),
        .irq_level   (irq)
    );

    function automatic logic [31:0] cw(bit en, bit quiet, logic [1:0] w);
        return {en, quiet, 4'b0, w, 24'b0};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [31:0] w);
        we = 1'b1;
        wdata = w;
        step();
        we = 1'b0;
    endtask

    task automatic wait_start();
        int n = 0;
        while (!drv && n < 500) begin
            step();
            n++;
        end
    endtask

    task automatic meas_low(output int len);
        len = 0;
        while (drv && len < 50) begin
            len++;
            step();
        end
    endtask

    // Drives 17 slots from the slot-0 sample clock; optional noise and write.
    task automatic run_slots(logic [NS-1:0] pat, bit noise, bit do_wr,
                             logic [31:0] wword, logic [NS-1:0] prev, string req);
        for (int i = 0; i < NS * 3; i++) begin
            int s = i / 3;
            int p = i % 3;
            periph_pull = (p == 0) ? pat[s] : (noise && !pat[s]);
            if (do_wr && i == 20) begin
                we = 1'b1;
                wdata = wword;
            end else begin
                we = 1'b0;
            end
            if (i == 30) chk("R9 mid-frame hold", 32'(irq), 32'(prev));
            chk("R4 line released in slots", 32'(drv), 0);
            step();
        end
        periph_pull = 1'b0;
        we = 1'b0;
        chk(req, 32'(irq), 32'(pat));
    endtask

    task automatic t_reset();
        chk("R11 reset pull", 32'(drv), 0);
        chk("R11 reset irq", 32'(irq), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            if (drv) chk("R11 idle after reset", 32'(drv), 0);
        end
        chk("R11 irq idle", 32'(irq), 0);
    endtask

    task automatic t_continuous();
        int len;
        wr(cw(1, 0, 2'b00));
        chk("R2 no drive before start", 32'(drv), 0);
        step();
        chk("R2 start next clock", 32'(drv), 1);
        meas_low(len);
        chk("R3 width 00", len, 4);
        run_slots(17'h10005, 0, 0, 0, '0, "R4 pattern A");
        meas_low(len);
        chk("R6 continuous stop", len, 3);
        chk("R6 turnaround released", 32'(drv), 0);
        step();
        chk("R7 restart after turnaround", 32'(drv), 1);
        chk("R9 hold across stop", 32'(irq), 32'h10005);
        meas_low(len);
        chk("R3 width 00 again", len, 4);
        run_slots(17'h0A0F0, 1, 1, cw(1, 1, 2'b10), 17'h10005, "R5 noise ignored");
        meas_low(len);
        chk("R10 stop keeps latched mode", len, 3);
        step();
        chk("R7 restart", 32'(drv), 1);
        meas_low(len);
        chk("R10 new width used", len, 8);
        run_slots(17'h15555, 0, 0, 0, 17'h0A0F0, "R4 pattern C");
        meas_low(len);
        chk("R6 quiet stop", len, 2);
        for (int i = 0; i < 20; i++) begin
            step();
            if (drv) chk("R8 quiet idle released", 32'(drv), 0);
        end
        chk("R9 hold during idle", 32'(irq), 32'h15555);
    endtask

    task automatic t_quiet();
        int len;
        periph_pull = 1'b1;
        step();
        periph_pull = 1'b0;
        chk("R8 host extends request", 32'(drv), 1);
        meas_low(len);
        chk("R8 extension length", len, 7);
        run_slots(17'h00001, 0, 0, 0, 17'h15555, "R4 pattern D");
        meas_low(len);
        chk("R6 quiet stop again", len, 2);
    endtask

    task automatic t_width();
        int len;
        step();
        wr(cw(1, 0, 2'b11));
        for (int i = 0; i < 5; i++) begin
            if (drv) chk("R10 idle kept after write", 32'(drv), 0);
            step();
        end
        periph_pull = 1'b1;
        step();
        periph_pull = 1'b0;
        meas_low(len);
        chk("R8 R3 code 11 extension", len, 7);
        run_slots(17'h10000, 0, 0, 0, 17'h00001, "R4 slot 16 io check");
        meas_low(len);
        chk("R6 continuous stop after switch", len, 3);
        step();
        chk("R7 restart", 32'(drv), 1);
        meas_low(len);
        chk("R3 width 11", len, 8);
        run_slots(17'h0FFFF, 0, 0, 0, 17'h10000, "R4 pattern F");
        meas_low(len);
        chk("R6 stop", len, 3);
    endtask

    task automatic t_disable();
        int len;
        step();
        step();
        wr(cw(0, 0, 2'b00));
        chk("R1 pull released", 32'(drv), 0);
        chk("R1 irq cleared", 32'(irq), 0);
        for (int i = 0; i < 60; i++) begin
            periph_pull = i[0];
            step();
            if (drv || irq != '0) chk("R1 disabled quiet", {15'b0, drv, irq}, 0);
        end
        periph_pull = 1'b0;
        wr(cw(1, 0, 2'b01));
        wait_start();
        chk("R1 no stale irq", 32'(irq), 0);
        meas_low(len);
        chk("R3 width 01", len, 6);
        run_slots(17'h0AAAA, 0, 0, 0, '0, "R4 pattern G");
        meas_low(len);
        chk("R6 stop", len, 3);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        t_continuous();
        t_quiet();
        t_width();
        t_disable();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule